// File: doc/BRIEF.md
# Status Byte and Service-Request Controller

This block holds an 8-bit instrument status byte and decides when the instrument asks the bus controller for service. Other logic reports events as single-cycle pulses: self-test failure, syntax error, message available and parameter error. A level input reports that the instrument has settled, and a 0-to-1 change of that level counts as an event. Each event latches its own status bit until something clears it.

An 8-bit enable mask selects which events may raise a service request. A request is raised only when an enabled status bit changes from 0 to 1. The request sets status bit 6 and drives `srq_o`. Once bit 6 is set, further rising events leave it set, so the first enabled rise is the one that raises the request. The byte is read in two ways. A status query clears the whole byte once it has reported a pending request. A serial poll acknowledges the request by clearing only bit 6. Strobes for clear-status, device-clear and universal device-clear come from a command decoder outside this block.

Top module: `status_srq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the status byte, the mask, `srq_o`, `query_data_o` and `poll_data_o` are all 0. If `settled_i` is high when reset ends, bit 2 is the only status bit set one cycle later.
- R2: A pulse on `ev_selftest_i`, `ev_syntax_i`, `ev_msg_i` or `ev_param_i` sets status bit 7, 5, 4 or 0 respectively, and the bit stays set until it is cleared. Bits 3 and 1 always read 0.
- R3: Status bit 2 is set on a cycle where `settled_i` is 1 and was 0 on the previous cycle. A level that stays high does not set the bit again after it has been cleared.
- R4: Suppose a status bit with its mask bit set goes from 0 to 1. Then bit 6 and `srq_o` are 1 one cycle after the event. An event whose mask bit is 0 raises no request.
- R5: Mask bit 6 has no effect. A mask of 0x40 never raises a request.
- R6: An event on a bit that is already 1 is not a 0-to-1 change and raises no request, even when that bit is enabled in the mask.
- R7: A `query_i` strobe puts the current byte on `query_data_o` one cycle later. If bit 6 was set in that value, the whole byte is 0 afterwards. Otherwise the byte is unchanged.
- R8: A `poll_i` strobe puts the current byte on `poll_data_o` one cycle later and clears bit 6 only. A second poll returns the byte with bit 6 at 0.
- R9: `clr_status_i` and `dev_clr_i` clear the status byte to 0. An event pulse in the same cycle as any clear still sets its bit.
- R10: `mask_wr_i` loads `mask_data_i` into the mask. Reset, `dev_clr_i` and `univ_clr_i` clear the mask, and a clear wins over a write in the same cycle.
- R11: `srq_o` is 1 exactly while status bit 6 is set.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| ev_selftest_i | input | 1 | Self-test failure pulse (bit 7) |
| ev_syntax_i | input | 1 | Syntax error pulse (bit 5) |
| ev_msg_i | input | 1 | Message available pulse (bit 4) |
| ev_param_i | input | 1 | Parameter error pulse (bit 0) |
| settled_i | input | 1 | Settled condition level; its rising edge sets bit 2 |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_data_i | input | 8 | New mask value |
| query_i | input | 1 | Status query strobe (clear-on-read when a request is pending) |
| poll_i | input | 1 | Serial poll strobe |
| clr_status_i | input | 1 | Clear status byte strobe |
| dev_clr_i | input | 1 | Device clear: clears the status byte and the mask |
| univ_clr_i | input | 1 | Universal device clear: clears the mask |
| query_data_o | output | 8 | Byte returned by the last query |
| poll_data_o | output | 8 | Byte returned by the last serial poll |
| srq_o | output | 1 | Service request output |

## Verification
The assertions check on every cycle that the unused bits read 0 and that `srq_o` rises only after an event pulse. They also check that a poll with no new event drops the request, and that a pending-request query, a clear-status or a device-clear with no event leaves the byte at 0. The mask clears are checked the same way. Other behaviour needs scenarios from the bench:
- the first-rise-only rule,
- the ignored mask bit 6,
- the second poll without bit 6,
- a query without a pending request leaving the byte untouched,
- an event winning over a clear in the same cycle,
- the settled level not setting bit 2 again.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int SB_W        = 8;
  localparam int B_SELFTEST  = 7;
  localparam int B_REQ       = 6;
  localparam int B_SYNTAX    = 5;
  localparam int B_MSG       = 4;
  localparam int B_SETTLED   = 2;
  localparam int B_PARAM     = 0;
  // Bits that may be set by events and may raise a request (bit 6 excluded).
  localparam logic [SB_W-1:0] EVENT_BITS =
    (SB_W'(1) << B_SELFTEST) | (SB_W'(1) << B_SYNTAX) | (SB_W'(1) << B_MSG) |
    (SB_W'(1) << B_SETTLED)  | (SB_W'(1) << B_PARAM);
endpackage

// File: rtl/stb_rise_det.sv
module stb_rise_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_i;
  end

  // During reset the previous level is forced to 0, so a level that is
  // already high when reset ends counts as a rise.
  assign rise_o = rst ? '0 : (level_i & ~prev_q);
endmodule

// File: rtl/stb_mask_reg.sv
module stb_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) mask_o <= '0;
    else if (wr_i)    mask_o <= data_i;
  end
endmodule

// File: rtl/stb_status_reg.sv
module stb_status_reg
  import stb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [SB_W-1:0] set_i,
  input  logic [SB_W-1:0] mask_i,
  input  logic            clr_i,
  input  logic            query_i,
  input  logic            poll_i,
  output logic [SB_W-1:0] sb_o
);
  logic [SB_W-1:0] sb_q;
  logic [SB_W-1:0] base;
  logic [SB_W-1:0] rise_vec;
  logic [SB_W-1:0] sb_d;
  logic            wipe;

  // A query clears the byte only when it reports a pending request.
  assign wipe     = clr_i | (query_i & sb_q[B_REQ]);
  // Only a 0-to-1 change of an enabled event bit raises a request.
  assign rise_vec = set_i & ~sb_q & mask_i & EVENT_BITS;

  always_comb begin
    base = wipe ? '0 : sb_q;
    if (poll_i) base[B_REQ] = 1'b0;
    sb_d = (base | (set_i & EVENT_BITS)) & (EVENT_BITS | (SB_W'(1) << B_REQ));
    sb_d[B_REQ] = base[B_REQ] | (|rise_vec);
  end

  always_ff @(posedge clk) begin
    if (rst) sb_q <= '0;
    else     sb_q <= sb_d;
  end

  assign sb_o = sb_q;
endmodule

// File: rtl/stb_readout.sv
module stb_readout #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         query_i,
  input  logic         poll_i,
  input  logic [W-1:0] sb_i,
  output logic [W-1:0] query_data_o,
  output logic [W-1:0] poll_data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      query_data_o <= '0;
      poll_data_o  <= '0;
    end else begin
      if (query_i) query_data_o <= sb_i;
      if (poll_i)  poll_data_o  <= sb_i;
    end
  end
endmodule

// File: rtl/status_srq_ctrl.sv
module status_srq_ctrl
  import stb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_selftest_i,
  input  logic            ev_syntax_i,
  input  logic            ev_msg_i,
  input  logic            ev_param_i,
  input  logic            settled_i,
  input  logic            mask_wr_i,
  input  logic [SB_W-1:0] mask_data_i,
  input  logic            query_i,
  input  logic            poll_i,
  input  logic            clr_status_i,
  input  logic            dev_clr_i,
  input  logic            univ_clr_i,
  output logic [SB_W-1:0] query_data_o,
  output logic [SB_W-1:0] poll_data_o,
  output logic            srq_o
);
  logic            settled_rise;
  logic [SB_W-1:0] set_vec;
  logic [SB_W-1:0] mask_q;
  logic [SB_W-1:0] sb_q;

  stb_rise_det #(.W(1)) u_settled (
    .clk(clk), .rst(rst), .level_i(settled_i), .rise_o(settled_rise)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[B_SELFTEST] = ev_selftest_i;
    set_vec[B_SYNTAX]   = ev_syntax_i;
    set_vec[B_MSG]      = ev_msg_i;
    set_vec[B_SETTLED]  = settled_rise;
    set_vec[B_PARAM]    = ev_param_i;
  end

  stb_mask_reg #(.W(SB_W)) u_mask (
    .clk(clk), .rst(rst), .clr_i(dev_clr_i | univ_clr_i),
    .wr_i(mask_wr_i), .data_i(mask_data_i), .mask_o(mask_q)
  );

  stb_status_reg u_status (
    .clk(clk), .rst(rst), .set_i(set_vec), .mask_i(mask_q),
    .clr_i(clr_status_i | dev_clr_i), .query_i(query_i), .poll_i(poll_i),
    .sb_o(sb_q)
  );

  stb_readout #(.W(SB_W)) u_read (
    .clk(clk), .rst(rst), .query_i(query_i), .poll_i(poll_i), .sb_i(sb_q),
    .query_data_o(query_data_o), .poll_data_o(poll_data_o)
  );

  assign srq_o = sb_q[B_REQ];
endmodule

// File: rtl/status_srq_ctrl_chk.sv
module status_srq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       poll_i,
  input logic       query_i,
  input logic       clr_status_i,
  input logic       dev_clr_i,
  input logic       univ_clr_i,
  input logic [7:0] set_vec,
  input logic [7:0] sb_q,
  input logic [7:0] mask_q,
  input logic [7:0] query_data_o,
  input logic [7:0] poll_data_o,
  input logic       srq_o
);
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (query_data_o[3] == 1'b0) && (query_data_o[1] == 1'b0) &&
    (poll_data_o[3] == 1'b0) && (poll_data_o[1] == 1'b0));

  p_srq_needs_event_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(srq_o) |-> $past(|set_vec));

  p_query_wipe_r7: assert property (@(posedge clk) disable iff (rst)
    (query_i && sb_q[6] && (set_vec == 8'h00)) |=> (sb_q == 8'h00));

  p_poll_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (poll_i && (set_vec == 8'h00)) |=> !srq_o);

  p_clear_byte_r9: assert property (@(posedge clk) disable iff (rst)
    ((clr_status_i || dev_clr_i) && (set_vec == 8'h00)) |=> (sb_q == 8'h00));

  p_mask_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (dev_clr_i || univ_clr_i) |=> (mask_q == 8'h00));
endmodule

bind status_srq_ctrl status_srq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .poll_i(poll_i), .query_i(query_i),
  .clr_status_i(clr_status_i), .dev_clr_i(dev_clr_i), .univ_clr_i(univ_clr_i),
  .set_vec(set_vec), .sb_q(sb_q), .mask_q(mask_q),
  .query_data_o(query_data_o), .poll_data_o(poll_data_o), .srq_o(srq_o)
);

// File: tb/status_srq_ctrl_tb.sv
module status_srq_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_st = 0, ev_sy = 0, ev_ms = 0, ev_pa = 0, settled = 0;
  logic mask_wr = 0, query = 0, poll = 0, clr_st = 0, dclr = 0, uclr = 0;
  logic [7:0] mask_data = 0;
  logic [7:0] q_data, p_data;
  logic srq;

  int n_chk = 0, n_err = 0;
  logic [7:0] e_sb = 0, e_mask = 0, e_q = 0, e_p = 0;
  logic e_prev = 0;

  always #2 clk = ~clk;

  status_srq_ctrl u_dut (
    .clk(clk), .rst(rst), .ev_selftest_i(ev_st), .ev_syntax_i(ev_sy),
    .ev_msg_i(ev_ms), .ev_param_i(ev_pa), .settled_i(settled),
    .mask_wr_i(mask_wr), .mask_data_i(mask_data), .query_i(query),
    .poll_i(poll), .clr_status_i(clr_st), .dev_clr_i(dclr),
    .univ_clr_i(uclr), .query_data_o(q_data), .poll_data_o(p_data),
    .srq_o(srq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Expected next state, derived from the requirements.
  function automatic logic [7:0] next_sb(input logic [7:0] sb, input logic [7:0] m,
      input logic [7:0] setv, input logic wipe, input logic ack);
    logic [7:0] b;
    logic [7:0] r;
    r = setv & ~sb & m & 8'hB5;
    b = wipe ? 8'h00 : sb;
    if (ack) b[6] = 1'b0;
    b = b | setv;
    b[6] = b[6] | (|r);
    return b;
  endfunction

  task automatic step(input logic st, sy, ms, pa, se, q, p, cs, dc, uc, mw,
                      input logic [7:0] md, input string tag);
    logic [7:0] setv;
    ev_st = st; ev_sy = sy; ev_ms = ms; ev_pa = pa; settled = se;
    query = q; poll = p; clr_st = cs; dclr = dc; uclr = uc; mask_wr = mw; mask_data = md;
    setv = {st, 1'b0, sy, ms, 1'b0, se & ~e_prev, 1'b0, pa};
    if (q) e_q = e_sb;
    if (p) e_p = e_sb;
    e_sb = next_sb(e_sb, e_mask, setv, cs | dc | (q & e_sb[6]), p);
    if (dc | uc) e_mask = 8'h00; else if (mw) e_mask = md;
    e_prev = se;
    @(posedge clk); #1;
    chk({tag, " R11 srq"}, {7'd0, srq}, {7'd0, e_sb[6]});
    if (q) chk({tag, " R7 query"}, q_data, e_q);
    if (p) chk({tag, " R8 poll"}, p_data, e_p);
    ev_st = 0; ev_sy = 0; ev_ms = 0; ev_pa = 0; query = 0; poll = 0;
    clr_st = 0; dclr = 0; uclr = 0; mask_wr = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    settled = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset srq", {7'd0, srq}, 8'h00);
    chk("R1 reset query", q_data, 8'h00);
    chk("R1 reset poll", p_data, 8'h00);
    rst = 1'b0;
    step(0,0,0,0,1, 0,0,0,0,0, 0,8'h00, "R1 settle");
    step(0,0,0,0,1, 1,0,0,0,0, 0,8'h00, "R1 q");
    chk("R1 only settled bit", q_data, 8'h04);
    step(0,0,0,0,1, 0,0,1,0,0, 0,8'h00, "R3 clr");
    step(0,0,0,0,1, 1,0,0,0,0, 0,8'h00, "R3 q");
    chk("R3 held level no reset", q_data, 8'h00);
    step(0,1,0,0,1, 0,0,0,0,0, 0,8'h00, "R4 masked");
    chk("R4 masked no srq", {7'd0, srq}, 8'h00);
    step(0,0,0,0,1, 0,0,0,0,0, 1,8'h40, "R5 wr");
    step(0,0,0,1,1, 0,0,0,0,0, 0,8'h00, "R5 ev");
    chk("R5 mask bit6 ignored", {7'd0, srq}, 8'h00);
    step(0,0,0,0,1, 1,0,0,0,0, 0,8'h00, "R2 q");
    chk("R2 bits latched", q_data, 8'h21);
    step(0,0,0,0,1, 0,0,0,0,0, 1,8'h01, "R6 wr");
    step(0,0,0,1,1, 0,0,0,0,0, 0,8'h00, "R6 ev");
    chk("R6 already set no srq", {7'd0, srq}, 8'h00);
    step(0,0,0,0,1, 0,0,1,0,0, 0,8'h00, "R4 clr");
    step(0,0,0,1,1, 0,0,0,0,0, 0,8'h00, "R4 ev");
    chk("R4 request raised", {7'd0, srq}, 8'h01);
    step(0,0,0,0,1, 1,0,0,0,0, 0,8'h00, "R7 q1");
    chk("R7 query with req", q_data, 8'h41);
    step(0,0,0,0,1, 1,0,0,0,0, 0,8'h00, "R7 q2");
    chk("R7 byte wiped", q_data, 8'h00);
    step(0,0,0,1,1, 0,0,0,0,0, 0,8'h00, "R8 ev");
    step(0,0,0,0,1, 0,1,0,0,0, 0,8'h00, "R8 p1");
    chk("R8 first poll", p_data, 8'h41);
    chk("R8 srq dropped", {7'd0, srq}, 8'h00);
    step(0,0,0,0,1, 0,1,0,0,0, 0,8'h00, "R8 p2");
    chk("R8 second poll", p_data, 8'h01);
    step(0,0,1,0,1, 0,0,1,0,0, 0,8'h00, "R9 win");
    step(0,0,0,0,1, 1,0,0,0,0, 0,8'h00, "R9 q");
    chk("R9 event beats clear", q_data, 8'h10);
    step(0,0,0,0,1, 0,0,0,1,0, 0,8'h00, "R10 dclr");
    step(0,0,0,1,1, 0,0,0,0,0, 0,8'h00, "R10 ev");
    chk("R10 mask cleared by dev clr", {7'd0, srq}, 8'h00);
    step(0,0,0,0,1, 1,0,0,0,0, 0,8'h00, "R9 q2");
    chk("R9 dev clr wiped byte", q_data, 8'h01);
    step(0,0,0,0,1, 0,0,0,0,0, 1,8'h80, "R10 wr");
    step(0,0,0,0,1, 0,0,0,0,1, 1,8'h80, "R10 uclr");
    step(1,0,0,0,1, 0,0,0,0,0, 0,8'h00, "R10 ev2");
    chk("R10 univ clr beats write", {7'd0, srq}, 8'h00);
    step(1,1,1,1,0, 0,0,0,0,0, 0,8'h00, "R2 all");
    step(0,0,0,0,1, 1,0,0,0,0, 0,8'h00, "R2 q2");
    chk("R2 unused bits zero", q_data & 8'h0A, 8'h00);
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] md;
      md = 8'($urandom);
      step($urandom_range(0,9) == 0, $urandom_range(0,9) == 0,
           $urandom_range(0,9) == 0, $urandom_range(0,9) == 0,
           ($urandom_range(0,9) == 0) ? ~settled : settled,
           $urandom_range(0,6) == 0, $urandom_range(0,6) == 0,
           $urandom_range(0,30) == 0, $urandom_range(0,50) == 0,
           $urandom_range(0,50) == 0, $urandom_range(0,15) == 0, md, "rand");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule